// File: doc/BRIEF.md
# Rank Refresh Scheduler and Power-State Tracker

This block looks after a single DRAM rank. A free-running interval counter marks when a refresh falls due. The refresh sequencer then waits for accesses in flight to finish while rows stay open. Next it closes every open bank with one precharge-all command, or skips that step when the banks are already closed. It then holds the rank in refresh for a fixed time. The rank is offered to the command scheduler only while the sequencer sits in its quiet state.

A second machine follows the rank's power condition. It takes its inputs from the refresh sequencer, from activate pulses, from the live count of open banks and from a power-down request. It has five states: idle with all banks closed, refreshing, precharged power-down, active, and active power-down. A pending fall back to idle after the last bank closes is cancelled when a new activate arrives first. A bank of counters adds up the clock cycles spent in each power state.

Top module: `rank_refresh_pwr`

## Requirements
- R1: After a synchronous reset the refresh state output reads 0 (idle, encoding idle=0, drain=1, precharge=2, refresh=3), the power state reads 0, the precharge-all and refresh pulses are low, `avail_o` is high and every state-time counter is zero.
- R2: A refresh falls due on clock edge number `REFI_CYC` after reset is released and every `REFI_CYC` edges after that, however long each refresh lasts. On a due edge the idle refresh state moves to drain. A due edge seen outside idle is remembered and acted on once the state is idle again.
- R3: The drain state holds while `busy_i` is high, and moves to precharge on the first edge at which `busy_i` is low.
- R4: `avail_o` is high exactly when the refresh state is idle.
- R5: In the precharge state, if `all_pre_i` is high the next edge starts the refresh directly, with no precharge-all. Otherwise, at the first edge with `pre_ok_i` high, `pre_all_o` pulses for one cycle, and the refresh starts `TRP_CYC` edges later. `ref_o` pulses for one cycle in the first refresh cycle.
- R6: The refresh state lasts exactly `RFC_CYC` cycles and then returns to idle.
- R7: The power state is encoded idle=0, refresh=1, precharged power-down=2, active=3, active power-down=4. From idle an `act_i` pulse leads to active. From idle, with the refresh state idle, `pdn_i` leads to precharged power-down, which returns to idle when `pdn_i` drops.
- R8: From active, `pdn_i` high with the refresh state idle leads to active power-down. That state returns to active when `pdn_i` drops or the refresh state leaves idle.
- R9: From active, the power state falls to idle on the (`IDLE_DLY`+1)-th consecutive edge at which `act_cnt_i` is zero and `act_i` is low. An activate or a nonzero count inside that window cancels the fall.
- R10: From idle or active, the power state moves to refresh on the edge after the refresh state becomes refresh. It returns to idle on the edge after the refresh ends. Precharged power-down is left for idle on the edge after the refresh state leaves idle.
- R11: Counter k in `st_time_o` (bits k*`CNT_W` upward) adds one on every clock edge at which the power state equals k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Accesses to the rank still outstanding |
| all_pre_i | input | 1 | Every bank of the rank is precharged |
| pre_ok_i | input | 1 | Precharge is allowed on every open bank |
| act_i | input | 1 | A bank activate is issued this cycle |
| pdn_i | input | 1 | Power-down requested |
| act_cnt_i | input | ACT_W | Number of banks currently open |
| ref_state_o | output | 2 | Refresh sequencer state |
| pwr_state_o | output | 3 | Power state |
| pre_all_o | output | 1 | Precharge-all command pulse |
| ref_o | output | 1 | Refresh command pulse |
| avail_o | output | 1 | Rank may be scheduled |
| st_time_o | output | 5*CNT_W | Cycles spent in each power state |

## Verification
The bench builds the block with a 40-cycle refresh interval, a 6-cycle refresh, a 3-cycle precharge delay and an idle delay of 2. With these values three complete refresh rounds fit into about 120 cycles. One round goes through the precharge-all path, one skips it, and one starts while the rank is in power-down. The short idle delay allows an activate to land in the last cycle of the fall-to-idle window. The bench also checks that the due points stay on a fixed 40-cycle grid whatever the drain length.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_DRAIN = 2'd1,
    RS_PRE   = 2'd2,
    RS_RUN   = 2'd3
  } ref_st_e;

  typedef enum logic [2:0] {
    PS_IDLE    = 3'd0,
    PS_REF     = 3'd1,
    PS_PRE_PDN = 3'd2,
    PS_ACT     = 3'd3,
    PS_ACT_PDN = 3'd4
  } pwr_st_e;

  localparam int NUM_PWR = 5;
endpackage

// File: rtl/rfp_refresh_fsm.sv
module rfp_refresh_fsm
  import rfp_pkg::*;
#(
  parameter int REFI_CYC = 7800,
  parameter int RFC_CYC  = 260,
  parameter int TRP_CYC  = 14
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    busy_i,
  input  logic    all_pre_i,
  input  logic    pre_ok_i,
  output ref_st_e state_o,
  output logic    pre_all_o,
  output logic    ref_o
);
  localparam int IW   = $clog2(REFI_CYC);
  localparam int TMAX = (RFC_CYC > TRP_CYC) ? RFC_CYC : TRP_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  logic [IW-1:0] iv_cnt;
  logic [TW-1:0] wait_cnt;
  logic          due_pend;
  logic          pre_sent;
  logic          due_hit;

  assign due_hit = (iv_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      iv_cnt    <= IW'(REFI_CYC - 1);
      wait_cnt  <= '0;
      due_pend  <= 1'b0;
      pre_sent  <= 1'b0;
      state_o   <= RS_IDLE;
      pre_all_o <= 1'b0;
      ref_o     <= 1'b0;
    end else begin
      pre_all_o <= 1'b0;
      ref_o     <= 1'b0;
      iv_cnt    <= due_hit ? IW'(REFI_CYC - 1) : iv_cnt - 1'b1;
      if (due_hit && state_o != RS_IDLE) due_pend <= 1'b1;
      case (state_o)
        RS_IDLE: begin
          if (due_hit || due_pend) begin
            state_o  <= RS_DRAIN;
            due_pend <= 1'b0;
          end
        end
        RS_DRAIN: begin
          if (!busy_i) state_o <= RS_PRE;
        end
        RS_PRE: begin
          if (!pre_sent) begin
            if (all_pre_i) begin
              state_o  <= RS_RUN;
              wait_cnt <= TW'(RFC_CYC - 1);
              ref_o    <= 1'b1;
            end else if (pre_ok_i) begin
              pre_all_o <= 1'b1;
              pre_sent  <= 1'b1;
              wait_cnt  <= TW'(TRP_CYC - 1);
            end
          end else if (wait_cnt == '0) begin
            state_o  <= RS_RUN;
            pre_sent <= 1'b0;
            wait_cnt <= TW'(RFC_CYC - 1);
            ref_o    <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        RS_RUN: begin
          if (wait_cnt == '0) state_o <= RS_IDLE;
          else wait_cnt <= wait_cnt - 1'b1;
        end
        default: state_o <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfp_power_fsm.sv
module rfp_power_fsm
  import rfp_pkg::*;
#(
  parameter int ACT_W    = 4,
  parameter int IDLE_DLY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ref_st_e          ref_st_i,
  input  logic             act_i,
  input  logic             pdn_i,
  input  logic [ACT_W-1:0] act_cnt_i,
  output pwr_st_e          state_o
);
  localparam int DW = $clog2(IDLE_DLY + 1);

  logic [DW-1:0] dly_cnt;
  logic          dly_pend;
  logic          ref_run;
  logic          ref_idle;
  logic          banks_shut;

  assign ref_run    = (ref_st_i == RS_RUN);
  assign ref_idle   = (ref_st_i == RS_IDLE);
  assign banks_shut = (act_cnt_i == '0) && !act_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o  <= PS_IDLE;
      dly_cnt  <= '0;
      dly_pend <= 1'b0;
    end else begin
      case (state_o)
        PS_IDLE: begin
          if (ref_run)                  state_o <= PS_REF;
          else if (act_i)               state_o <= PS_ACT;
          else if (pdn_i && ref_idle)   state_o <= PS_PRE_PDN;
        end
        PS_REF: begin
          if (!ref_run) state_o <= PS_IDLE;
        end
        PS_PRE_PDN: begin
          if (!pdn_i || !ref_idle) state_o <= PS_IDLE;
        end
        PS_ACT: begin
          if (ref_run) begin
            state_o  <= PS_REF;
            dly_pend <= 1'b0;
          end else if (banks_shut) begin
            if (!dly_pend) begin
              dly_pend <= 1'b1;
              dly_cnt  <= DW'(IDLE_DLY - 1);
            end else if (dly_cnt == '0) begin
              dly_pend <= 1'b0;
              state_o  <= PS_IDLE;
            end else begin
              dly_cnt <= dly_cnt - 1'b1;
            end
          end else begin
            dly_pend <= 1'b0;
            if (pdn_i && ref_idle) state_o <= PS_ACT_PDN;
          end
        end
        PS_ACT_PDN: begin
          if (!pdn_i || !ref_idle) state_o <= PS_ACT;
        end
        default: state_o <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfp_state_timer.sv
module rfp_state_timer
  import rfp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pwr_st_e                  state_i,
  output logic [NUM_PWR*CNT_W-1:0] time_o
);
  for (genvar k = 0; k < NUM_PWR; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) time_o[k*CNT_W +: CNT_W] <= '0;
      else if (state_i == pwr_st_e'(k))
        time_o[k*CNT_W +: CNT_W] <= time_o[k*CNT_W +: CNT_W] + 1'b1;
    end
  end
endmodule

// File: rtl/rank_refresh_pwr.sv
module rank_refresh_pwr
  import rfp_pkg::*;
#(
  parameter int REFI_CYC = 7800,
  parameter int RFC_CYC  = 260,
  parameter int TRP_CYC  = 14,
  parameter int IDLE_DLY = 4,
  parameter int ACT_W    = 4,
  parameter int CNT_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busy_i,
  input  logic                     all_pre_i,
  input  logic                     pre_ok_i,
  input  logic                     act_i,
  input  logic                     pdn_i,
  input  logic [ACT_W-1:0]         act_cnt_i,
  output logic [1:0]               ref_state_o,
  output logic [2:0]               pwr_state_o,
  output logic                     pre_all_o,
  output logic                     ref_o,
  output logic                     avail_o,
  output logic [NUM_PWR*CNT_W-1:0] st_time_o
);
  ref_st_e ref_st;
  pwr_st_e pwr_st;

  rfp_refresh_fsm #(
    .REFI_CYC(REFI_CYC), .RFC_CYC(RFC_CYC), .TRP_CYC(TRP_CYC)
  ) u_ref (
    .clk(clk), .rst(rst), .busy_i(busy_i), .all_pre_i(all_pre_i),
    .pre_ok_i(pre_ok_i), .state_o(ref_st), .pre_all_o(pre_all_o), .ref_o(ref_o)
  );

  rfp_power_fsm #(
    .ACT_W(ACT_W), .IDLE_DLY(IDLE_DLY)
  ) u_pwr (
    .clk(clk), .rst(rst), .ref_st_i(ref_st), .act_i(act_i), .pdn_i(pdn_i),
    .act_cnt_i(act_cnt_i), .state_o(pwr_st)
  );

  rfp_state_timer #(
    .CNT_W(CNT_W)
  ) u_tim (
    .clk(clk), .rst(rst), .state_i(pwr_st), .time_o(st_time_o)
  );

  assign ref_state_o = ref_st;
  assign pwr_state_o = pwr_st;
  assign avail_o     = (ref_st == RS_IDLE);
endmodule

// File: rtl/rank_refresh_pwr_chk.sv
module rank_refresh_pwr_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy_i,
  input logic       pdn_i,
  input logic [1:0] ref_state_o,
  input logic [2:0] pwr_state_o,
  input logic       pre_all_o,
  input logic       ref_o,
  input logic       avail_o
);
  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_state_o == 2'd1 && busy_i) |=> (ref_state_o == 2'd1));

  // R5
  pre_in_pre_chk: assert property (@(posedge clk) disable iff (rst)
    pre_all_o |-> (ref_state_o == 2'd2));

  // R5
  pre_single_chk: assert property (@(posedge clk) disable iff (rst)
    pre_all_o |=> !pre_all_o);

  // R5
  ref_start_chk: assert property (@(posedge clk) disable iff (rst)
    ref_o |-> (ref_state_o == 2'd3 && !avail_o));

  // R8
  act_pdn_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state_o == 3'd4 && !pdn_i) |=> (pwr_state_o == 3'd3));

  // R7
  pwr_legal_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_state_o <= 3'd4);

  // R10
  ref_pwr_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state_o == 3'd1 && ref_state_o == 2'd3) |=> (pwr_state_o == 3'd1));
endmodule

bind rank_refresh_pwr rank_refresh_pwr_chk u_chk (
  .clk(clk), .rst(rst), .busy_i(busy_i), .pdn_i(pdn_i),
  .ref_state_o(ref_state_o), .pwr_state_o(pwr_state_o),
  .pre_all_o(pre_all_o), .ref_o(ref_o), .avail_o(avail_o)
);

// File: tb/tb_rank_refresh_pwr.sv
module tb_rank_refresh_pwr;
  localparam int CW = 16;
  localparam int NV = 39;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy = 1'b0, all_pre = 1'b1, pre_ok = 1'b0, act = 1'b0, pdn = 1'b0;
  logic [3:0] act_cnt = '0;
  logic [1:0] ref_state;
  logic [2:0] pwr_state;
  logic pre_all, ref_p, avail;
  logic [5*CW-1:0] st_time;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_t [5];

  always #2.5 clk = ~clk;

  rank_refresh_pwr #(
    .REFI_CYC(40), .RFC_CYC(6), .TRP_CYC(3), .IDLE_DLY(2), .ACT_W(4), .CNT_W(CW)
  ) dut (
    .clk(clk), .rst(rst), .busy_i(busy), .all_pre_i(all_pre), .pre_ok_i(pre_ok),
    .act_i(act), .pdn_i(pdn), .act_cnt_i(act_cnt), .ref_state_o(ref_state),
    .pwr_state_o(pwr_state), .pre_all_o(pre_all), .ref_o(ref_p), .avail_o(avail),
    .st_time_o(st_time)
  );

  // Bench-side model of R11: count edges per observed power state.
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 5; k++) exp_t[k] <= 0;
    end else if (pwr_state <= 3'd4) begin
      exp_t[pwr_state] <= exp_t[pwr_state] + 1;
    end
  end

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected under 5000", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
    end
  endtask

  typedef struct packed {
    logic [7:0] n;
    logic       busy, allp, pok, act, pdn;
    logic [3:0] acnt;
    logic [1:0] eref;
    logic [2:0] epwr;
    logic       epre, erefo;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t v(int n, bit b, bit ap, bit po, bit a, bit pd, int ac,
                             int er, int ep, bit epr, bit erf, int rq);
    vec_t r;
    r.n = 8'(n); r.busy = b; r.allp = ap; r.pok = po; r.act = a; r.pdn = pd;
    r.acnt = 4'(ac); r.eref = 2'(er); r.epwr = 3'(ep); r.epre = epr; r.erefo = erf;
    r.req = 4'(rq);
    return r;
  endfunction

  // hold  busy allp pok act pdn acnt | ref pwr pre refo | requirement
  localparam vec_t TBL [NV] = '{
    v( 3, 0,1,0,0,0,0, 0,0,0,0,  7),  // R7 idle rest
    v( 1, 0,0,0,1,0,1, 0,3,0,0,  7),  // R7 activate
    v( 5, 0,0,0,0,0,1, 0,3,0,0,  9),  // R9 banks open
    v( 1, 0,0,0,0,1,1, 0,4,0,0,  8),  // R8 enter act pdn
    v( 3, 0,0,0,0,1,1, 0,4,0,0,  8),  // R8
    v( 1, 0,0,0,0,0,1, 0,3,0,0,  8),  // R8 exit
    v( 2, 0,1,0,0,0,0, 0,3,0,0,  9),  // R9 window open
    v( 1, 0,0,0,1,0,1, 0,3,0,0,  9),  // R9 cancel by activate
    v( 1, 0,0,0,0,0,1, 0,3,0,0,  9),  // R9
    v( 3, 0,1,0,0,0,0, 0,0,0,0,  9),  // R9 fall to idle
    v( 2, 0,1,0,0,1,0, 0,2,0,0,  7),  // R7 pre pdn
    v( 1, 0,1,0,0,0,0, 0,0,0,0,  7),  // R7 exit
    v( 1, 0,0,0,1,0,1, 0,3,0,0,  7),  // R7
    v(14, 1,0,0,0,0,1, 0,3,0,0,  2),  // R2 edge 39 not due
    v( 1, 1,0,0,0,0,1, 1,3,0,0,  2),  // R2 edge 40 due
    v( 3, 1,0,0,0,0,1, 1,3,0,0,  3),  // R3 drain holds
    v( 1, 0,0,0,0,0,1, 2,3,0,0,  3),  // R3 leave drain
    v( 2, 0,0,0,0,0,1, 2,3,0,0,  5),  // R5 waits for pre_ok
    v( 1, 0,0,1,0,0,1, 2,3,1,0,  5),  // R5 precharge-all
    v( 1, 0,1,0,0,0,0, 2,3,0,0,  5),  // R5
    v( 1, 0,1,0,0,0,0, 2,3,0,0,  5),  // R5
    v( 1, 0,1,0,0,0,0, 3,0,0,1,  5),  // R5 refresh TRP later
    v( 1, 0,1,0,0,0,0, 3,1,0,0, 10),  // R10 power refresh
    v( 4, 0,1,0,0,0,0, 3,1,0,0,  6),  // R6 still refreshing
    v( 1, 0,1,0,0,0,0, 0,1,0,0,  6),  // R6 done
    v( 1, 0,1,0,0,0,0, 0,0,0,0, 10),  // R10 back to idle
    v(22, 0,1,0,0,0,0, 0,0,0,0,  2),  // R2 edge 79
    v( 1, 0,1,0,0,0,0, 1,0,0,0,  2),  // R2 edge 80 due
    v( 1, 0,1,0,0,0,0, 2,0,0,0,  3),  // R3 no busy
    v( 1, 0,1,0,0,0,0, 3,0,0,1,  5),  // R5 skip precharge
    v( 1, 0,1,0,0,0,0, 3,1,0,0, 10),  // R10
    v( 5, 0,1,0,0,0,0, 0,1,0,0,  6),  // R6
    v( 1, 0,1,0,0,0,0, 0,0,0,0, 10),  // R10
    v( 1, 0,1,0,0,1,0, 0,2,0,0,  7),  // R7 pre pdn
    v(29, 0,1,0,0,1,0, 0,2,0,0,  7),  // R7 edge 119
    v( 1, 0,1,0,0,1,0, 1,2,0,0,  2),  // R2 edge 120 due
    v( 1, 0,1,0,0,1,0, 2,0,0,0, 10),  // R10 pdn left
    v( 1, 0,1,0,0,1,0, 3,0,0,1,  5),  // R5
    v( 1, 0,1,0,0,1,0, 3,1,0,0, 10)   // R10
  };

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ref_state", ref_state, 0);
    chk("R1 pwr_state", pwr_state, 0);
    chk("R1 pre_all", pre_all, 0);
    chk("R1 ref_o", ref_p, 0);
    chk("R1 avail", avail, 1);
    chk("R1 counters", (st_time == '0) ? 1 : 0, 1);

    for (int i = 0; i < NV; i++) begin
      busy = TBL[i].busy; all_pre = TBL[i].allp; pre_ok = TBL[i].pok;
      act = TBL[i].act; pdn = TBL[i].pdn; act_cnt = TBL[i].acnt;
      repeat (int'(TBL[i].n)) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (ref_state != TBL[i].eref || pwr_state != TBL[i].epwr ||
          pre_all != TBL[i].epre || ref_p != TBL[i].erefo) begin
        n_bad++;
        $display("FAIL R%0d row %0d: actual ref=%0d pwr=%0d pre=%0d refo=%0d expected ref=%0d pwr=%0d pre=%0d refo=%0d",
                 TBL[i].req, i, ref_state, pwr_state, pre_all, ref_p,
                 TBL[i].eref, TBL[i].epwr, TBL[i].epre, TBL[i].erefo);
      end
      // R4
      chk("R4 avail", avail, (TBL[i].eref == 2'd0) ? 1 : 0);
    end

    busy = 1'b0; all_pre = 1'b1; pre_ok = 1'b0; act = 1'b0; pdn = 1'b0; act_cnt = '0;
    // R11 state-time counters against bench tally
    for (int k = 0; k < 5; k++)
      chk($sformatf("R11 time[%0d]", k), int'(st_time[k*CW +: CW]), exp_t[k]);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 ref_state after reset", ref_state, 0);
    chk("R1 pwr_state after reset", pwr_state, 0);
    chk("R1 avail after reset", avail, 1);
    chk("R1 counters after reset", (st_time == '0) ? 1 : 0, 1);
    rst = 1'b0;

    summary_and_end();
  end
endmodule